// File: doc/BRIEF.md
# Two-Button Clock Time-Setting Controller

This block keeps a 24-hour time of day and lets a user correct it with two buttons, Mode and Advance. The button levels arrive already debounced. A periodic sample strobe decides when the buttons are examined. While running, the block counts seconds on a 1 Hz strobe and carries them into minutes and hours. A separate blink strobe drives a flash phase, which shows the user which field is being edited.

Editing is a fixed sequence. The user holds Mode to leave the running state and edit hours, then holds Mode again to edit minutes, then holds Mode once more to return to the full display. Advance steps the selected field once per sample strobe. Each Mode press counts as a single step, because the block waits for Mode to be released before the next state accepts input. Timekeeping resumes with seconds at zero at the sample strobe that sees Mode released after the last step. The outputs are the three binary time fields and two blank-enables, one for the hour field and one for the minute field, which drive a display stage outside the block.

Top module: `time_set_ctrl`

## Requirements
- R1: After reset the time is 00:00:00. The block is running, both blank-enables are low, and the flash phase is in its visible half (phase 0).
- R2: While running, each 1 Hz strobe adds one second. Seconds 59 wraps to 0 and carries one minute, minute 59 carries one hour, and 23:59:59 becomes 00:00:00.
- R3: While running, Mode alone at a sample strobe enters the hour-hold state. In that state the minute blank-enable is high and the hour field is shown steadily. Advance alone while running has no effect.
- R4: Buttons are acted on only at a sample strobe. A Mode press produces exactly one state step however many sample strobes it spans. A sample strobe with Mode up ends each hold state.
- R5: In hour editing, Advance alone at a sample strobe adds one hour, with 23 wrapping to 0, and the minutes stay the same.
- R6: The flash phase toggles on every blink strobe. In an editing state with neither button down, the edited field's blank-enable equals the flash phase. While either button is down, that field is shown (blank-enable low).
- R7: In hour editing, Mode alone at a sample strobe enters the minute-hold state, where the hour blank-enable is high and the minutes are shown steadily. Releasing Mode then starts minute editing, in which the hour field stays blanked.
- R8: In minute editing, Advance alone at a sample strobe adds one minute, with 59 wrapping to 0 and no carry into hours.
- R9: In minute editing, Mode alone at a sample strobe enters a full-display hold with both blank-enables low. A sample strobe with Mode up then resumes running and sets seconds to 0.
- R10: In every state other than running, the 1 Hz strobe changes no field.
- R11: A sample strobe with both buttons down changes neither the state nor any field.
- R12: When a 1 Hz strobe and a state change fall in the same cycle, leaving the running state still counts that second. Resuming running takes priority over the strobe, so seconds become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | One-cycle strobe at which the buttons are examined |
| sec_tick | input | 1 | One-cycle strobe once per second |
| blink_tick | input | 1 | One-cycle strobe that toggles the flash phase |
| mode_btn | input | 1 | Debounced Mode button level, 1 = pressed |
| adv_btn | input | 1 | Debounced Advance button level, 1 = pressed |
| hours | output | 5 | Hours, binary 0 to 23 |
| minutes | output | 6 | Minutes, binary 0 to 59 |
| seconds | output | 6 | Seconds, binary 0 to 59 |
| hour_blank | output | 1 | 1 = hour field dark |
| min_blank | output | 1 | 1 = minute field dark |

## Verification
Two pairs of events can coincide in one cycle, and the bench provokes both by driving the two strobes in the same cycle. In the first case, a Mode press at a sample strobe coincides with a 1 Hz strobe while running. The bench expects the hour-hold blanking and a seconds value one higher. In the second case, the Mode release that ends the full-display hold coincides with a 1 Hz strobe. The bench expects seconds to read exactly zero, not one. The same stimulus table also places Advance together with the 1 Hz strobe during hour editing, and expects the hour to move while the seconds stay frozen.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_HOLD_HR,
        ST_SET_HR,
        ST_HOLD_MN,
        ST_SET_MN,
        ST_HOLD_RUN
    } tsc_state_e;

    typedef struct packed {
        logic mode;
        logic adv;
    } btn_s;

    typedef struct packed {
        logic inc_hr;
        logic inc_mn;
        logic zero_sec;
        logic run;
    } cmd_s;

    function automatic logic mode_only(btn_s b);
        return b.mode && !b.adv;
    endfunction

    function automatic logic adv_only(btn_s b);
        return b.adv && !b.mode;
    endfunction

    function automatic logic none_down(btn_s b);
        return !b.adv && !b.mode;
    endfunction

    function automatic logic is_hold(tsc_state_e s);
        return (s == ST_HOLD_HR) || (s == ST_HOLD_MN) || (s == ST_HOLD_RUN);
    endfunction

endpackage

// File: rtl/tsc_wrap_ctr.sv
module tsc_wrap_ctr #(
    parameter int MOD = 60,
    localparam int W = $clog2(MOD)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         at_max
);

    localparam logic [W-1:0] TOP = W'(MOD - 1);

    assign at_max = (value == TOP);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            value <= '0;
        end else if (inc) begin
            value <= at_max ? '0 : value + 1'b1;
        end
    end

    // R2: field never leaves its range
    p_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        value <= TOP);

    // R5 / R8: stepping past the top returns to zero
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && value == TOP) |=> (value == '0));

    // R10: without a step or clear the field holds
    p_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(value));

endmodule

// File: rtl/tsc_fsm.sv
module tsc_fsm import tsc_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       sample_tick,
    input  logic       blink_tick,
    input  btn_s       btn,
    output tsc_state_e state,
    output logic       blink_ph,
    output cmd_s       cmd
);

    tsc_state_e state_nx;

    always_comb begin
        state_nx = state;
        if (sample_tick) begin
            unique case (state)
                ST_RUN:      if (mode_only(btn)) state_nx = ST_HOLD_HR;
                ST_HOLD_HR:  if (!btn.mode)      state_nx = ST_SET_HR;
                ST_SET_HR:   if (mode_only(btn)) state_nx = ST_HOLD_MN;
                ST_HOLD_MN:  if (!btn.mode)      state_nx = ST_SET_MN;
                ST_SET_MN:   if (mode_only(btn)) state_nx = ST_HOLD_RUN;
                ST_HOLD_RUN: if (!btn.mode)      state_nx = ST_RUN;
                default:                         state_nx = ST_RUN;
            endcase
        end
    end

    always_comb begin
        cmd.run      = (state == ST_RUN);
        cmd.inc_hr   = sample_tick && (state == ST_SET_HR) && adv_only(btn);
        cmd.inc_mn   = sample_tick && (state == ST_SET_MN) && adv_only(btn);
        cmd.zero_sec = sample_tick && (state == ST_HOLD_RUN) && !btn.mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_RUN;
            blink_ph <= 1'b0;
        end else begin
            state <= state_nx;
            if (blink_tick) blink_ph <= !blink_ph;
        end
    end

    // R11: both buttons at a sample strobe leave the state alone
    p_both_down_r11: assert property (@(posedge clk) disable iff (rst)
        (sample_tick && btn.mode && btn.adv) |=> $stable(state));

    // R4: a held Mode cannot leave a hold state
    p_one_step_r4: assert property (@(posedge clk) disable iff (rst)
        (is_hold(state) && btn.mode) |=> $stable(state));

    // R4: state moves only at a sample strobe
    p_need_sample_r4: assert property (@(posedge clk) disable iff (rst)
        !sample_tick |=> $stable(state));

    // R6: flash phase toggles on every blink strobe
    p_blink_toggle_r6: assert property (@(posedge clk) disable iff (rst)
        blink_tick |=> (blink_ph != $past(blink_ph)));

endmodule

// File: rtl/tsc_blank.sv
module tsc_blank import tsc_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  tsc_state_e state,
    input  btn_s       btn,
    input  logic       blink_ph,
    output logic       hr_blank,
    output logic       mn_blank
);

    logic flash_dark;

    assign flash_dark = none_down(btn) && blink_ph;

    always_comb begin
        hr_blank = 1'b0;
        mn_blank = 1'b0;
        unique case (state)
            ST_HOLD_HR: mn_blank = 1'b1;
            ST_SET_HR: begin
                mn_blank = 1'b1;
                hr_blank = flash_dark;
            end
            ST_HOLD_MN: hr_blank = 1'b1;
            ST_SET_MN: begin
                hr_blank = 1'b1;
                mn_blank = flash_dark;
            end
            default: begin
                hr_blank = 1'b0;
                mn_blank = 1'b0;
            end
        endcase
    end

    // R6: a held button keeps the edited hour field lit
    p_steady_held_r6: assert property (@(posedge clk) disable iff (rst)
        ((btn.mode || btn.adv) && state == ST_SET_HR) |-> !hr_blank);

    // R9: full display in the final hold
    p_full_show_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD_RUN) |-> (!hr_blank && !mn_blank));

endmodule

// File: rtl/time_set_ctrl.sv
module time_set_ctrl import tsc_pkg::*; #(
    parameter int HRS_PER_DAY = 24,
    parameter int MIN_PER_HR  = 60,
    parameter int SEC_PER_MIN = 60,
    localparam int HW = $clog2(HRS_PER_DAY),
    localparam int MW = $clog2(MIN_PER_HR),
    localparam int SW = $clog2(SEC_PER_MIN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample_tick,
    input  logic          sec_tick,
    input  logic          blink_tick,
    input  logic          mode_btn,
    input  logic          adv_btn,
    output logic [HW-1:0] hours,
    output logic [MW-1:0] minutes,
    output logic [SW-1:0] seconds,
    output logic          hour_blank,
    output logic          min_blank
);

    btn_s       btn;
    cmd_s       cmd;
    tsc_state_e state;
    logic       blink_ph;
    logic       sec_step;
    logic       s_max, m_max, h_max;

    assign btn.mode = mode_btn;
    assign btn.adv  = adv_btn;
    assign sec_step = cmd.run && sec_tick;

    tsc_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sample_tick (sample_tick),
        .blink_tick  (blink_tick),
        .btn         (btn),
        .state       (state),
        .blink_ph    (blink_ph),
        .cmd         (cmd)
    );

    tsc_wrap_ctr #(.MOD(SEC_PER_MIN)) u_sec (
        .clk    (clk),
        .rst    (rst),
        .clr    (cmd.zero_sec),
        .inc    (sec_step),
        .value  (seconds),
        .at_max (s_max)
    );

    tsc_wrap_ctr #(.MOD(MIN_PER_HR)) u_min (
        .clk    (clk),
        .rst    (rst),
        .clr    (1'b0),
        .inc    (cmd.inc_mn || (sec_step && s_max)),
        .value  (minutes),
        .at_max (m_max)
    );

    tsc_wrap_ctr #(.MOD(HRS_PER_DAY)) u_hr (
        .clk    (clk),
        .rst    (rst),
        .clr    (1'b0),
        .inc    (cmd.inc_hr || (sec_step && s_max && m_max)),
        .value  (hours),
        .at_max (h_max)
    );

    tsc_blank u_blank (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .btn      (btn),
        .blink_ph (blink_ph),
        .hr_blank (hour_blank),
        .mn_blank (min_blank)
    );

    // R2: end of day rolls every field to zero
    p_day_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (sec_step && s_max && m_max && h_max)
        |=> (hours == '0 && minutes == '0 && seconds == '0));

    // R9 / R12: resuming the run starts at zero seconds
    p_restart_zero_r9: assert property (@(posedge clk) disable iff (rst)
        cmd.zero_sec |=> (seconds == '0));

    // R8: minute editing never touches hours
    p_no_carry_r8: assert property (@(posedge clk) disable iff (rst)
        cmd.inc_mn |=> $stable(hours));

endmodule

// File: tb/tb_time_set_ctrl.sv
module tb_time_set_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_tick = 1'b0, sec_tick = 1'b0, blink_tick = 1'b0;
    logic       mode_btn = 1'b0, adv_btn = 1'b0;
    logic [4:0] hours;
    logic [5:0] minutes, seconds;
    logic       hour_blank, min_blank;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    time_set_ctrl dut (
        .clk         (clk),
        .rst         (rst),
        .sample_tick (sample_tick),
        .sec_tick    (sec_tick),
        .blink_tick  (blink_tick),
        .mode_btn    (mode_btn),
        .adv_btn     (adv_btn),
        .hours       (hours),
        .minutes     (minutes),
        .seconds     (seconds),
        .hour_blank  (hour_blank),
        .min_blank   (min_blank)
    );

    typedef struct packed {
        logic       md, ad, st, sc, bk;
        logic [4:0] eh;
        logic [5:0] em, es;
        logic       hb, mb;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [0:NV-1] = '{
        '{0,0,0,1,0,  0,0,1, 0,0,  2},  // R2 tick
        '{0,0,0,1,0,  0,0,2, 0,0,  2},  // R2 tick
        '{1,0,1,1,0,  0,0,3, 0,1, 12},  // R12 press + tick
        '{1,0,1,0,0,  0,0,3, 0,1,  4},  // R4 held Mode, one step
        '{1,0,0,1,0,  0,0,3, 0,1, 10},  // R10 tick ignored
        '{0,0,1,0,0,  0,0,3, 0,1,  4},  // R4 release -> hour edit
        '{0,0,0,0,1,  0,0,3, 1,1,  6},  // R6 flash dark
        '{0,1,1,0,0,  1,0,3, 0,1,  5},  // R5 advance hour
        '{0,1,0,0,0,  1,0,3, 0,1,  5},  // R5 no sample, no step
        '{0,1,1,1,0,  2,0,3, 0,1, 10},  // R10 advance with tick
        '{1,1,1,0,0,  2,0,3, 0,1, 11},  // R11 both down
        '{0,0,0,0,1,  2,0,3, 0,1,  6},  // R6 flash lit
        '{1,0,1,0,0,  2,0,3, 1,0,  7},  // R7 minute hold
        '{1,0,1,0,0,  2,0,3, 1,0,  7},  // R7 still held
        '{0,0,1,0,0,  2,0,3, 1,0,  7},  // R7 minute edit
        '{0,0,0,0,1,  2,0,3, 1,1,  6},  // R6 minute flash dark
        '{0,1,1,0,0,  2,1,3, 1,0,  8},  // R8 advance minute
        '{0,1,1,0,0,  2,2,3, 1,0,  8},  // R8 advance minute
        '{1,0,1,0,0,  2,2,3, 0,0,  9},  // R9 full hold
        '{1,0,1,1,0,  2,2,3, 0,0, 10},  // R10 frozen in hold
        '{0,0,1,1,0,  2,2,0, 0,0, 12},  // R12 release + tick -> 0
        '{0,0,0,1,0,  2,2,1, 0,0,  2},  // R2 running again
        '{0,1,1,0,0,  2,2,1, 0,0,  3}   // R3 advance ignored
    };

    task automatic step(input logic md, ad, st, sc, bk);
        @(negedge clk);
        mode_btn = md; adv_btn = ad; sample_tick = st; sec_tick = sc; blink_tick = bk;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int eh, em, es, input logic ehb, emb);
        n_chk++;
        if (hours !== 5'(eh) || minutes !== 6'(em) || seconds !== 6'(es) ||
            hour_blank !== ehb || min_blank !== emb) begin
            n_fail++;
            $display("FAIL %s: got %0d:%0d:%0d hb=%b mb=%b, expected %0d:%0d:%0d hb=%b mb=%b",
                     req, hours, minutes, seconds, hour_blank, min_blank,
                     eh, em, es, ehb, emb);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        mode_btn = 0; adv_btn = 0; sample_tick = 0; sec_tick = 0; blink_tick = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    initial begin
        do_reset();
        check("R1", 0, 0, 0, 1'b0, 1'b0);

        // R4: Mode without a sample strobe does nothing
        step(1, 0, 0, 0, 0);
        check("R4", 0, 0, 0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].md, VEC[i].ad, VEC[i].st, VEC[i].sc, VEC[i].bk);
            check($sformatf("R%0d", VEC[i].rq), VEC[i].eh, VEC[i].em, VEC[i].es,
                  VEC[i].hb, VEC[i].mb);
        end

        // R1: reset from mid-run returns to the reset state
        do_reset();
        check("R1", 0, 0, 0, 1'b0, 1'b0);

        // R3: enter hour editing
        step(1, 0, 1, 0, 0);
        check("R3", 0, 0, 0, 1'b0, 1'b1);
        step(0, 0, 1, 0, 0);
        for (int i = 0; i < 24; i++) step(0, 1, 1, 0, 0);
        check("R5", 0, 0, 0, 1'b0, 1'b1);   // R5 full lap wraps 23 -> 0
        for (int i = 0; i < 23; i++) step(0, 1, 1, 0, 0);
        check("R5", 23, 0, 0, 1'b0, 1'b1);

        step(1, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        check("R7", 23, 0, 0, 1'b1, 1'b0);
        for (int i = 0; i < 60; i++) step(0, 1, 1, 0, 0);
        check("R8", 23, 0, 0, 1'b1, 1'b0);  // R8 wrap, hour unchanged
        for (int i = 0; i < 59; i++) step(0, 1, 1, 0, 0);
        check("R8", 23, 59, 0, 1'b1, 1'b0);

        step(1, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        check("R9", 23, 59, 0, 1'b0, 1'b0);

        for (int i = 0; i < 59; i++) step(0, 0, 0, 1, 0);
        check("R2", 23, 59, 59, 1'b0, 1'b0);
        step(0, 0, 0, 1, 0);
        check("R2", 0, 0, 0, 1'b0, 1'b0);   // R2 day rollover

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule